// File: doc/BRIEF.md
# Scratchpad Buffer Command Engine

This block holds a single 32-byte staging page that sits in front of a paged memory. Data reaches the page over a byte-level serial transport. The host opens a transaction with a frame-start strobe and then sends a command byte. For a write, it sends a 16-bit target address and then data. For a read, it pulls back the address, a status byte and the staged data, so it can confirm both before a later copy stage moves the page into the main array.

During a write, the engine records several things: the last byte offset it actually stored, whether data ran past the top of the page, and whether the frame closed in the middle of a byte. Each of these is reported in a read-only status byte. The copy stage sees the target address, the status byte and a random-access read port into the page.

Top module: `scratch_cmd_engine`

## Requirements
- R1: After reset the target address, the status byte and every page byte are zero, the engine waits for a command, and `tx_valid` is low.
- R2: Command byte 0x0F starts a write. The next received byte is loaded into target address bits [7:0] as soon as it arrives. The byte after it is loaded into bits [15:8].
- R3: Write data is stored in consecutive page bytes, starting at the offset in target address bits [4:0]. Status bits [4:0] take that start offset when the high address byte arrives, and then follow the offset of each stored byte.
- R4: A data byte that arrives after offset 31 has been written sets status bit 6 (overflow). That byte and every later data byte of the transaction are discarded.
- R5: A frame-start strobe that ends a write data phase sets status bit 5 (partial) when `rx_tail_bits` is nonzero and status bit 6 is clear. The incomplete byte is never stored.
- R6: Receipt of command byte 0x0F clears status bits 7, 6 and 5.
- R7: After command byte 0xAA, each `tx_req` gives, in order, target address bits [7:0], target address bits [15:8], the status byte, and then the page bytes from the target offset up to offset 31. Each response appears on `tx_byte` with `tx_valid` high in the cycle after the request.
- R8: Once the read response has passed offset 31, and whenever no read command is active, `tx_req` returns 0xFF.
- R9: A frame-start strobe in any state abandons the current command and returns the engine to waiting for a command. The address, status and page contents are kept.
- R10: A command byte other than 0x0F or 0xAA makes the engine ignore all received bytes until the next frame-start strobe.
- R11: A pulse on `auth_ok` sets status bit 7. A write command byte arriving in the same cycle takes precedence and leaves the bit clear.
- R12: `ta_out` and `es_out` show the current target address and status byte. `cp_data` returns the page byte at `cp_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_rst | input | 1 | Frame-start / abort strobe from the transport |
| rx_tail_bits | input | 3 | Bits received in the final incomplete byte, sampled with `frame_rst` |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | Request for the next transmit byte |
| tx_valid | output | 1 | Transmit byte is valid (one cycle after `tx_req`) |
| tx_byte | output | 8 | Transmit byte |
| auth_ok | input | 1 | Copy stage reports an accepted authorisation |
| ta_out | output | 16 | Target address for the copy stage |
| es_out | output | 8 | Status: [4:0] ending offset, [5] partial, [6] overflow, [7] authorised |
| cp_addr | input | 5 | Copy-stage page read address |
| cp_data | output | 8 | Page byte at `cp_addr` |

## Verification
The hardest situations to reach combine the page boundary with the frame's end. Two cases matter most: a write that starts near offset 31 and runs exactly one byte past it, and a frame that closes on an incomplete byte after the overflow has already been flagged, where the partial flag must stay clear. The stimulus reaches these cases in two ways. Directed transactions start at offsets 28 and 31. Random transactions draw the start offset, the length (up to 36 bytes) and the tail bit count. After every write, a full readback is run past offset 31 into the 0xFF region, and each byte is compared against a bench model of the page.

// File: rtl/scp_pkg.sv
package scp_pkg;
    localparam int unsigned OFS_W = 5;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_TA1,
        ST_TA2,
        ST_WDATA,
        ST_RDATA,
        ST_DROP
    } scp_state_e;

    typedef enum logic [1:0] {
        PH_TA1,
        PH_TA2,
        PH_ES,
        PH_DATA
    } scp_phase_e;
endpackage

// File: rtl/scp_store.sv
module scp_store #(
    parameter int unsigned AW = 5,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[i] <= '0;
            end else if (we && (waddr == AW'(i))) begin
                mem_q[i] <= wdata;
            end
        end
    end

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];
endmodule

// File: rtl/scp_readout.sv
module scp_readout
    import scp_pkg::*;
(
    input  scp_phase_e       phase,
    input  logic [OFS_W:0]   ptr,
    input  logic [15:0]      ta,
    input  logic [7:0]       es,
    input  logic [7:0]       sp_data,
    output logic [7:0]       byte_o
);
    always_comb begin
        unique case (phase)
            PH_TA1:  byte_o = ta[7:0];
            PH_TA2:  byte_o = ta[15:8];
            PH_ES:   byte_o = es;
            default: byte_o = ptr[OFS_W] ? 8'hFF : sp_data;
        endcase
    end
endmodule

// File: rtl/scratch_cmd_engine.sv
module scratch_cmd_engine
    import scp_pkg::*;
#(
    parameter logic [7:0] CMD_WRITE = 8'h0F,
    parameter logic [7:0] CMD_READ  = 8'hAA
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_rst,
    input  logic [2:0]       rx_tail_bits,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic             tx_req,
    output logic             tx_valid,
    output logic [7:0]       tx_byte,
    input  logic             auth_ok,
    output logic [15:0]      ta_out,
    output logic [7:0]       es_out,
    input  logic [OFS_W-1:0] cp_addr,
    output logic [7:0]       cp_data
);
    typedef struct packed {
        scp_state_e       st;
        scp_phase_e       ph;
        logic [OFS_W:0]   ptr;
        logic [15:0]      ta;
        logic [OFS_W-1:0] eo;
        logic             pf;
        logic             of;
        logic             aa;
        logic             tx_valid;
        logic [7:0]       tx_byte;
    } regs_t;

    regs_t            q, d;
    logic             sp_we;
    logic [OFS_W-1:0] sp_waddr;
    logic [7:0]       sp_rdata;
    logic [7:0]       rd_byte;
    logic [7:0]       es_w;
    scp_state_e       st_now;

    assign es_w   = {q.aa, q.of, q.pf, q.eo};
    assign st_now = q.st;

    scp_store #(.AW(OFS_W), .DW(8)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (sp_we),
        .waddr   (sp_waddr),
        .wdata   (rx_byte),
        .raddr_a (q.ptr[OFS_W-1:0]),
        .rdata_a (sp_rdata),
        .raddr_b (cp_addr),
        .rdata_b (cp_data)
    );

    scp_readout u_readout (
        .phase   (q.ph),
        .ptr     (q.ptr),
        .ta      (q.ta),
        .es      (es_w),
        .sp_data (sp_rdata),
        .byte_o  (rd_byte)
    );

    always_comb begin
        d        = q;
        d.tx_valid = 1'b0;
        sp_we    = 1'b0;
        sp_waddr = q.ptr[OFS_W-1:0];

        if (auth_ok) begin
            d.aa = 1'b1;
        end

        if (tx_req) begin
            d.tx_valid = 1'b1;
            if (q.st == ST_RDATA) begin
                d.tx_byte = rd_byte;
                unique case (q.ph)
                    PH_TA1:  d.ph = PH_TA2;
                    PH_TA2:  d.ph = PH_ES;
                    PH_ES:   d.ph = PH_DATA;
                    default: if (!q.ptr[OFS_W]) d.ptr = q.ptr + 1'b1;
                endcase
            end else begin
                d.tx_byte = 8'hFF;
            end
        end

        if (frame_rst) begin
            if (q.st == ST_WDATA && rx_tail_bits != 3'd0 && !q.of) begin
                d.pf = 1'b1;
            end
            d.st = ST_CMD;
        end else if (rx_valid) begin
            unique case (q.st)
                ST_CMD: begin
                    if (rx_byte == CMD_WRITE) begin
                        d.st = ST_TA1;
                        d.aa = 1'b0;
                        d.of = 1'b0;
                        d.pf = 1'b0;
                    end else if (rx_byte == CMD_READ) begin
                        d.st  = ST_RDATA;
                        d.ph  = PH_TA1;
                        d.ptr = {1'b0, q.ta[OFS_W-1:0]};
                    end else begin
                        d.st = ST_DROP;
                    end
                end
                ST_TA1: begin
                    d.ta[7:0] = rx_byte;
                    d.st      = ST_TA2;
                end
                ST_TA2: begin
                    d.ta[15:8] = rx_byte;
                    d.ptr      = {1'b0, q.ta[OFS_W-1:0]};
                    d.eo       = q.ta[OFS_W-1:0];
                    d.st       = ST_WDATA;
                end
                ST_WDATA: begin
                    if (!q.of) begin
                        if (q.ptr[OFS_W]) begin
                            d.of = 1'b1;
                        end else begin
                            sp_we = 1'b1;
                            d.eo  = q.ptr[OFS_W-1:0];
                            d.ptr = q.ptr + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign tx_valid = q.tx_valid;
    assign tx_byte  = q.tx_byte;
    assign ta_out   = q.ta;
    assign es_out   = es_w;
endmodule

// File: rtl/scp_checker.sv
module scp_checker
    import scp_pkg::*;
#(
    parameter logic [7:0] CMD_WRITE = 8'h0F
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_rst,
    input logic             rx_valid,
    input logic [7:0]       rx_byte,
    input logic             tx_req,
    input logic             tx_valid,
    input logic [7:0]       es_out,
    input scp_state_e       st,
    input logic             sp_we,
    input logic [OFS_W-1:0] sp_waddr
);
    a_r7_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> tx_valid);

    a_r7_no_unrequested_resp: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_req |=> !tx_valid);

    a_r9_frame_rst_to_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        frame_rst |=> st == ST_CMD);

    a_r4_no_store_after_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        sp_we |-> !es_out[6]);

    a_r4_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        es_out[6] && !(rx_valid && !frame_rst && st == ST_CMD && rx_byte == CMD_WRITE)
        |=> es_out[6]);

    a_r3_end_offset_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        sp_we |=> es_out[4:0] == $past(sp_waddr));

    a_r5_partial_needs_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(es_out[5]) |-> !es_out[6]);

    a_r10_drop_never_stores: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_DROP |-> !sp_we);
endmodule

bind scratch_cmd_engine scp_checker #(.CMD_WRITE(CMD_WRITE)) u_scp_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_rst (frame_rst),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .tx_req    (tx_req),
    .tx_valid  (tx_valid),
    .es_out    (es_out),
    .st        (st_now),
    .sp_we     (sp_we),
    .sp_waddr  (sp_waddr)
);

// File: tb/scratch_cmd_engine_bench.sv
`timescale 1ns/1ps
module scratch_cmd_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_rst = 1'b0;
    logic [2:0]  rx_tail_bits = 3'd0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        tx_req = 1'b0;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        auth_ok = 1'b0;
    logic [15:0] ta_out;
    logic [7:0]  es_out;
    logic [4:0]  cp_addr = 5'd0;
    logic [7:0]  cp_data;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0]  m_sp [32];
    logic [15:0] m_ta;
    logic [4:0]  m_eo;
    bit          m_pf, m_of, m_aa, m_wdata;
    int          m_ptr;

    always #2.5 clk = ~clk;

    scratch_cmd_engine u_scratch_cmd_engine (
        .clk, .rst_n, .frame_rst, .rx_tail_bits, .rx_valid, .rx_byte,
        .tx_req, .tx_valid, .tx_byte, .auth_ok, .ta_out, .es_out,
        .cp_addr, .cp_data
    );

    function automatic logic [7:0] m_es();
        return {m_aa, m_of, m_pf, m_eo};
    endfunction

    function automatic logic [7:0] exp_read(input int idx);
        int off;
        off = int'(m_ta[4:0]) + idx - 3;
        if (idx == 0) return m_ta[7:0];
        if (idx == 1) return m_ta[15:8];
        if (idx == 2) return m_es();
        return (off < 32) ? m_sp[off] : 8'hFF;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic send_frame(input logic [2:0] tail);
        frame_rst = 1'b1;
        rx_tail_bits = tail;
        tick();
        frame_rst = 1'b0;
        rx_tail_bits = 3'd0;
        if (m_wdata && tail != 3'd0 && !m_of) m_pf = 1'b1;
        m_wdata = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        rx_valid = 1'b1;
        rx_byte = b;
        tick();
        rx_valid = 1'b0;
    endtask

    task automatic pull(output logic [7:0] b, output logic v);
        tx_req = 1'b1;
        tick();
        tx_req = 1'b0;
        b = tx_byte;
        v = tx_valid;
    endtask

    task automatic do_write(input logic [15:0] ta, input int n, input logic [2:0] tail);
        send_frame(3'd0);
        send_byte(8'h0F);
        m_aa = 0; m_of = 0; m_pf = 0;
        send_byte(ta[7:0]);
        send_byte(ta[15:8]);
        m_ta = ta; m_eo = ta[4:0]; m_ptr = int'(ta[4:0]); m_wdata = 1'b1;
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            b = 8'($urandom);
            send_byte(b);
            if (!m_of) begin
                if (m_ptr == 32) m_of = 1'b1;
                else begin
                    m_sp[m_ptr] = b; m_eo = 5'(m_ptr); m_ptr++;
                end
            end
        end
        send_frame(tail);
    endtask

    task automatic do_read_check(input string tag);
        logic [7:0] b;
        logic v;
        int cnt;
        send_frame(3'd0);
        send_byte(8'hAA);
        cnt = 3 + (32 - int'(m_ta[4:0])) + 2;
        for (int i = 0; i < cnt; i++) begin
            pull(b, v);
            check({tag, " R7 byte"}, {23'd0, v, b}, {23'd0, 1'b1, exp_read(i)});
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        logic v;
        void'($urandom(32'd5417));
        for (int i = 0; i < 32; i++) m_sp[i] = 8'h00;
        m_ta = 0; m_eo = 0; m_pf = 0; m_of = 0; m_aa = 0; m_wdata = 0; m_ptr = 0;
        tick(); tick();
        rst_n = 1'b1;
        tick();

        check("R1 tx_valid", {31'd0, tx_valid}, 0);
        check("R1 ta_out", {16'd0, ta_out}, 0);
        check("R1 es_out", {24'd0, es_out}, 0);
        cp_addr = 5'd17; #1;
        check("R1 page byte", {24'd0, cp_data}, 0);

        pull(b, v);
        check("R8 idle request", {23'd0, v, b}, {23'd0, 1'b1, 8'hFF});
        do_read_check("R1 reset readback");

        do_write(16'h123C, 6, 3'd0);
        check("R4 overflow flag", {24'd0, es_out}, {24'd0, m_es()});
        check("R4 overflow set", {31'd0, es_out[6]}, 1);
        check("R2 target address", {16'd0, ta_out}, {16'd0, 16'h123C});
        do_read_check("R4 R8 boundary");

        do_write(16'h0A1F, 2, 3'd4);
        check("R5 no partial after overflow", {31'd0, es_out[5]}, 0);
        check("R3 end offset 31", {27'd0, es_out[4:0]}, 31);

        do_write(16'h7703, 2, 3'd5);
        check("R5 partial flag", {31'd0, es_out[5]}, 1);
        check("R3 end offset", {27'd0, es_out[4:0]}, 4);
        cp_addr = 5'd5; #1;
        check("R5 tail not stored", {24'd0, cp_data}, {24'd0, m_sp[5]});
        do_read_check("R5 readback");

        auth_ok = 1'b1; tick(); auth_ok = 1'b0; m_aa = 1'b1;
        check("R11 auth bit", {31'd0, es_out[7]}, 1);
        send_frame(3'd0);
        send_byte(8'h0F);
        m_aa = 0; m_of = 0; m_pf = 0;
        check("R6 flags cleared", {29'd0, es_out[7:5]}, 0);
        send_byte(8'h44);
        m_ta[7:0] = 8'h44;
        send_frame(3'd6);
        check("R9 abort keeps partial clear", {31'd0, es_out[5]}, 0);
        check("R9 low address kept", {16'd0, ta_out}, {16'd0, m_ta});
        do_read_check("R9 after abort");

        send_frame(3'd0);
        auth_ok = 1'b1;
        rx_valid = 1'b1; rx_byte = 8'h0F;
        tick();
        auth_ok = 1'b0; rx_valid = 1'b0;
        m_aa = 0; m_of = 0; m_pf = 0;
        check("R11 write wins over auth", {31'd0, es_out[7]}, 0);

        send_frame(3'd0);
        send_byte(8'h55);
        send_byte(8'h0F);
        send_byte(8'h99);
        send_byte(8'hAA);
        pull(b, v);
        check("R10 dropped command", {23'd0, v, b}, {23'd0, 1'b1, 8'hFF});
        check("R10 address untouched", {16'd0, ta_out}, {16'd0, m_ta});
        check("R10 status untouched", {24'd0, es_out}, {24'd0, m_es()});

        for (int it = 0; it < 30; it++) begin
            logic [15:0] ta;
            int n;
            logic [2:0] tail;
            ta = 16'($urandom);
            if (it % 5 == 0) ta[4:0] = 5'd31;
            n = int'($urandom_range(0, 36));
            tail = ($urandom_range(0, 1) == 1) ? 3'($urandom_range(1, 7)) : 3'd0;
            do_write(ta, n, tail);
            check("R3 R4 R5 status", {24'd0, es_out}, {24'd0, m_es()});
            check("R2 address", {16'd0, ta_out}, {16'd0, m_ta});
            do_read_check("R7 random");
        end

        for (int a = 0; a < 32; a++) begin
            cp_addr = 5'(a); #1;
            check("R12 copy port", {24'd0, cp_data}, {24'd0, m_sp[a]});
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule